// File: doc/BRIEF.md
# Display Controller Command FIFO Host Port

This block is the host side of a graphics display controller. A host drives a 16-bit bus with two byte-lane enables and uses three kinds of access. An address write selects one of 256 byte-wide control registers. A data write stores one or two bytes into the register file at that address. A status read returns an 8-bit status byte. Data written at address 0 also enters a 16-deep byte queue. Each queued byte carries a tag that marks it as a command opcode, a parameter, or an empty slot.

A downstream command processor drains the queue through a valid/ready pop port. The block keeps the head byte and its tag steady until the consumer takes it. As bytes leave, the block tracks command progress. A popped command byte clears the command-end flag and latches the opcode. Popped parameter bytes are gathered in order into a small buffer that the processor reads by index. A data write with the abort bit set at the command-control address empties the queue and returns the status to its idle value in a single step.

Back-pressure rules: `cmd_valid` stays high while the queue holds a byte. `cmd_data` and `cmd_kind` do not change until a cycle in which `cmd_ready` is high. A pop happens on a clock edge where both `cmd_valid` and `cmd_ready` are high. The host side has no stall signal. Bytes pushed into a full queue are dropped and flagged as an error.

Top module: `gdc_host_port`

## Requirements
- R1: After reset, the status byte is 0x23, the queue is empty (`cmd_valid` 0, `cmd_kind` 0), `ar_q` is 0 and `prm_count` is 0.
- R2: An address write loads `ar_q` from `host_wdata[7:0]`, but only when `host_be[0]` is 1. With `host_be[0]` at 0 the address is left unchanged.
- R3: A data write stores `host_wdata[15:8]` at register index `ar_q` when `host_be[1]` is 1. It stores `host_wdata[7:0]` at index `ar_q+1` (mod 256) when `host_be[0]` is 1. A disabled lane leaves its register unchanged. `regf_q` returns the register selected by `regf_idx`.
- R4: After a data write, `ar_q` advances by 2 (mod 256) when its bit 7 is 1. When bit 7 is 0, `ar_q` keeps its value.
- R5: A data write at address 0 queues the high byte first and the low byte second. The high byte's tag is command (2'b10) if status bit 5 is 1, and parameter (2'b01) otherwise. The low byte's tag is always parameter. An empty slot reads as tag 2'b00.
- R6: The pop port delivers bytes in first-in, first-out order. While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_data` and `cmd_kind` hold their values.
- R7: Status bit 0 is 1 exactly when the queue is empty. Status bit 1 is 1 exactly when fewer than 16 bytes are queued. Bits 6, 4, 3 and 2 read as 0.
- R8: A queued byte that finds no free slot is dropped and sets status bit 7. Free space is counted before any pop in the same cycle. With one slot free, the high byte is kept and the low byte is dropped.
- R9: A data write at address 2 with `host_be[1]` at 1 and `host_wdata[15]` at 1 empties the queue, sets the status to 0x23 and sets `prm_count` to 0, all in the next cycle. Any pop in that cycle is ignored.
- R10: Popping a command byte clears status bit 5, sets `cur_cmd` to that byte and sets `prm_count` to 0. Popping a parameter byte stores it at `prm_count` in the parameter buffer, which `prm_sel`/`prm_q` reads, and increments the count. The count stops at 16.
- R11: The cycle after a status read, `host_rdata` equals {8'h00, status}. It is 0 after any cycle without a status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr_we | input | 1 | Address-register write strobe |
| host_data_we | input | 1 | Data-register write strobe |
| host_stat_re | input | 1 | Status read strobe |
| host_be | input | 2 | Byte-lane enables: bit 1 is the high lane, bit 0 is the low lane |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered status read data |
| ar_q | output | 8 | Current address register |
| regf_idx | input | 8 | Register-file read index |
| regf_q | output | 8 | Register-file read data |
| cmd_valid | output | 1 | A queued byte is available |
| cmd_ready | input | 1 | The consumer takes the head byte |
| cmd_data | output | 8 | Head byte of the queue |
| cmd_kind | output | 2 | Head tag: 00 empty, 01 parameter, 10 command |
| cur_cmd | output | 8 | Last popped command byte |
| prm_count | output | 5 | Number of parameter bytes collected |
| prm_sel | input | 4 | Parameter buffer read index |
| prm_q | output | 8 | Parameter buffer read data |

## Verification
The properties assume that the host never raises an address write and a data write in the same cycle. The address-step checks would not apply to such a cycle. They also assume that abort is the only path that sets the command-end flag. The bench keeps within these limits: each task issues exactly one host access per cycle, and pops run only in cycles with no host write. A reference queue in the bench predicts tags, drops and the order of parameters. Soak traffic mixes writes, pops, stalled cycles and aborts, so the queue passes through its empty, single-free-slot and full levels many times.

// File: rtl/gdc_hp_pkg.sv
package gdc_hp_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    TAG_EMPTY = 2'b00,
    TAG_PARAM = 2'b01,
    TAG_CMD   = 2'b10
  } ent_tag_e;

  // status bit positions
  localparam int ST_ERR  = 7;
  localparam int ST_CEND = 5;
  localparam int ST_WRDY = 1;
  localparam int ST_WEMP = 0;

  localparam logic [BYTE_W-1:0] ST_IDLE = 8'h23;
endpackage

// File: rtl/gdc_hp_regs.sv
module gdc_hp_regs #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            addr_we,
  input  logic            data_we,
  input  logic [1:0]      be,
  input  logic [2*DW-1:0] wdata,
  input  logic [AW-1:0]   rd_idx,
  output logic [DW-1:0]   rd_q,
  output logic [AW-1:0]   ar_q
);
  localparam int NREG = 1 << AW;
  localparam logic [AW-1:0] STEP = AW'(2);

  logic [DW-1:0] regf [NREG];
  logic [AW-1:0] ar;
  logic [AW-1:0] ar_lo;

  assign ar_lo = ar + AW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ar <= '0;
    end else if (addr_we) begin
      if (be[0]) ar <= wdata[AW-1:0];
    end else if (data_we && ar[AW-1]) begin
      ar <= ar + STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (data_we && !addr_we) begin
      if (be[1]) regf[ar]    <= wdata[2*DW-1:DW];
      if (be[0]) regf[ar_lo] <= wdata[DW-1:0];
    end
  end

  assign rd_q = regf[rd_idx];
  assign ar_q = ar;
endmodule

// File: rtl/gdc_hp_fifo.sv
module gdc_hp_fifo
  import gdc_hp_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push_hi,
  input  logic [DW-1:0]              hi_data,
  input  ent_tag_e                   hi_tag,
  input  logic                       push_lo,
  input  logic [DW-1:0]              lo_data,
  input  ent_tag_e                   lo_tag,
  input  logic                       pop,
  output logic [DW-1:0]              head_data,
  output ent_tag_e                   head_tag,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty,
  output logic                       drop
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW-1:0] ent_d [DEPTH];
  ent_tag_e      ent_t [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr, lo_ptr;
  logic [CW-1:0] cnt, free;
  logic          hi_acc, lo_acc, pop_ok;
  logic [1:0]    n_push;

  assign free   = CW'(DEPTH) - cnt;
  assign hi_acc = push_hi && (free != '0);
  assign lo_acc = push_lo && (push_hi ? (free >= CW'(2)) : (free != '0));
  assign drop   = (push_hi && !hi_acc) || (push_lo && !lo_acc);
  assign lo_ptr = hi_acc ? wr_ptr + PW'(1) : wr_ptr;
  assign n_push = {1'b0, hi_acc} + {1'b0, lo_acc};
  assign empty  = (cnt == '0);
  assign full   = (cnt == CW'(DEPTH));
  assign pop_ok = pop && !empty;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= wr_ptr + PW'(n_push);
      rd_ptr <= rd_ptr + PW'(pop_ok);
      cnt    <= cnt + CW'(n_push) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) begin
        ent_d[k] <= '0;
        ent_t[k] <= TAG_EMPTY;
      end
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        if (flush) begin
          ent_t[k] <= TAG_EMPTY;
        end else if (hi_acc && wr_ptr == PW'(k)) begin
          ent_d[k] <= hi_data;
          ent_t[k] <= hi_tag;
        end else if (lo_acc && lo_ptr == PW'(k)) begin
          ent_d[k] <= lo_data;
          ent_t[k] <= lo_tag;
        end else if (pop_ok && rd_ptr == PW'(k)) begin
          ent_t[k] <= TAG_EMPTY;
        end
      end
    end
  end

  assign head_data = ent_d[rd_ptr];
  assign head_tag  = ent_t[rd_ptr];
  assign count     = cnt;
endmodule

// File: rtl/gdc_hp_prm.sv
module gdc_hp_prm #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       take_cmd,
  input  logic                       take_prm,
  input  logic [DW-1:0]              byte_in,
  input  logic [$clog2(DEPTH)-1:0]   sel,
  output logic [$clog2(DEPTH+1)-1:0] cnt,
  output logic [DW-1:0]              sel_q,
  output logic [DW-1:0]              cmd_q
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int SW = $clog2(DEPTH);

  logic [DW-1:0] pbuf [DEPTH];
  logic [CW-1:0] n;
  logic          room;

  assign room = (n < CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n     <= '0;
      cmd_q <= '0;
    end else if (clr) begin
      n <= '0;
    end else if (take_cmd) begin
      n     <= '0;
      cmd_q <= byte_in;
    end else if (take_prm && room) begin
      n <= n + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !clr && !take_cmd && take_prm && room)
      pbuf[n[SW-1:0]] <= byte_in;
  end

  assign cnt   = n;
  assign sel_q = pbuf[sel];
endmodule

// File: rtl/gdc_host_port.sv
module gdc_host_port
  import gdc_hp_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DEPTH     = 16,
  parameter int PRM_DEPTH = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           host_addr_we,
  input  logic                           host_data_we,
  input  logic                           host_stat_re,
  input  logic [1:0]                     host_be,
  input  logic [15:0]                    host_wdata,
  output logic [15:0]                    host_rdata,
  output logic [AW-1:0]                  ar_q,
  input  logic [AW-1:0]                  regf_idx,
  output logic [7:0]                     regf_q,
  output logic                           cmd_valid,
  input  logic                           cmd_ready,
  output logic [7:0]                     cmd_data,
  output logic [1:0]                     cmd_kind,
  output logic [7:0]                     cur_cmd,
  output logic [$clog2(PRM_DEPTH+1)-1:0] prm_count,
  input  logic [$clog2(PRM_DEPTH)-1:0]   prm_sel,
  output logic [7:0]                     prm_q
);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] A_FIFO = AW'(0);
  localparam logic [AW-1:0] A_CCTL = AW'(2);

  logic          fifo_wr, abort_hit, pop_fire;
  logic          st_err, st_ced;
  logic [7:0]    st_byte;
  ent_tag_e      hi_tag, head_tag;
  logic [CW-1:0] fifo_cnt;
  logic          f_full, f_empty, f_drop;

  gdc_hp_regs #(.AW(AW), .DW(BYTE_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_we (host_addr_we),
    .data_we (host_data_we),
    .be      (host_be),
    .wdata   (host_wdata),
    .rd_idx  (regf_idx),
    .rd_q    (regf_q),
    .ar_q    (ar_q)
  );

  assign fifo_wr   = host_data_we && !host_addr_we && (ar_q == A_FIFO);
  assign abort_hit = host_data_we && !host_addr_we && (ar_q == A_CCTL)
                     && host_be[1] && host_wdata[15];
  assign hi_tag    = st_ced ? TAG_CMD : TAG_PARAM;
  assign pop_fire  = cmd_valid && cmd_ready && !abort_hit;

  gdc_hp_fifo #(.DEPTH(DEPTH), .DW(BYTE_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (abort_hit),
    .push_hi   (fifo_wr),
    .hi_data   (host_wdata[15:8]),
    .hi_tag    (hi_tag),
    .push_lo   (fifo_wr),
    .lo_data   (host_wdata[7:0]),
    .lo_tag    (TAG_PARAM),
    .pop       (pop_fire),
    .head_data (cmd_data),
    .head_tag  (head_tag),
    .count     (fifo_cnt),
    .full      (f_full),
    .empty     (f_empty),
    .drop      (f_drop)
  );

  assign cmd_valid = !f_empty;
  assign cmd_kind  = head_tag;

  gdc_hp_prm #(.DEPTH(PRM_DEPTH), .DW(BYTE_W)) u_prm (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (abort_hit),
    .take_cmd (pop_fire && head_tag == TAG_CMD),
    .take_prm (pop_fire && head_tag == TAG_PARAM),
    .byte_in  (cmd_data),
    .sel      (prm_sel),
    .cnt      (prm_count),
    .sel_q    (prm_q),
    .cmd_q    (cur_cmd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_err <= 1'b0;
      st_ced <= 1'b1;
    end else if (abort_hit) begin
      st_err <= 1'b0;
      st_ced <= 1'b1;
    end else begin
      if (f_drop) st_err <= 1'b1;
      if (pop_fire && head_tag == TAG_CMD) st_ced <= 1'b0;
    end
  end

  always_comb begin
    st_byte          = '0;
    st_byte[ST_ERR]  = st_err;
    st_byte[ST_CEND] = st_ced;
    st_byte[ST_WRDY] = !f_full;
    st_byte[ST_WEMP] = f_empty;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            host_rdata <= '0;
    else if (host_stat_re) host_rdata <= {8'h00, st_byte};
    else                   host_rdata <= '0;
  end
endmodule

// File: rtl/gdc_host_port_chk.sv
module gdc_host_port_chk #(
  parameter int AW    = 8,
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       host_addr_we,
  input logic                       host_data_we,
  input logic                       host_stat_re,
  input logic [AW-1:0]              ar_q,
  input logic                       cmd_valid,
  input logic                       cmd_ready,
  input logic [7:0]                 cmd_data,
  input logic [1:0]                 cmd_kind,
  input logic [15:0]                host_rdata,
  input logic [7:0]                 st_byte,
  input logic [$clog2(DEPTH+1)-1:0] fifo_cnt,
  input logic                       abort_hit,
  input logic                       fifo_wr
);
  localparam int CW = $clog2(DEPTH+1);

  a_r9_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort_hit |=> (st_byte == 8'h23) && !cmd_valid);

  a_r6_hold_head: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !abort_hit) |=>
      (cmd_valid && $stable(cmd_data) && $stable(cmd_kind)));

  a_r4_ar_step: assert property (@(posedge clk) disable iff (!rst_n)
    (host_data_we && !host_addr_we && ar_q[AW-1]) |=> (ar_q == $past(ar_q) + AW'(2)));

  a_r4_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (host_data_we && !host_addr_we && !ar_q[AW-1]) |=> $stable(ar_q));

  a_r8_overflow_err: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && fifo_cnt == CW'(DEPTH)) |=> st_byte[7]);

  a_r7_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));

  a_r10_cmd_clears_end: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_kind == 2'b10 && !abort_hit) |=> !st_byte[5]);

  a_r11_status_read: assert property (@(posedge clk) disable iff (!rst_n)
    host_stat_re |=> (host_rdata == {8'h00, $past(st_byte)}));

  a_r5_valid_tagged: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_kind != 2'b00));
endmodule

bind gdc_host_port gdc_host_port_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_addr_we (host_addr_we),
  .host_data_we (host_data_we),
  .host_stat_re (host_stat_re),
  .ar_q         (ar_q),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .cmd_data     (cmd_data),
  .cmd_kind     (cmd_kind),
  .host_rdata   (host_rdata),
  .st_byte      (st_byte),
  .fifo_cnt     (fifo_cnt),
  .abort_hit    (abort_hit),
  .fifo_wr      (fifo_wr)
);

// File: tb/test_gdc_host_port.sv
module test_gdc_host_port;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_addr_we = 1'b0, host_data_we = 1'b0, host_stat_re = 1'b0;
  logic [1:0]  host_be = 2'b00;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic [7:0]  ar_q, regf_idx = '0, regf_q;
  logic        cmd_valid, cmd_ready = 1'b0;
  logic [7:0]  cmd_data, cur_cmd, prm_q;
  logic [1:0]  cmd_kind;
  logic [4:0]  prm_count;
  logic [3:0]  prm_sel = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gdc_host_port i_gdc_host_port (
    .clk(clk), .rst_n(rst_n), .host_addr_we(host_addr_we), .host_data_we(host_data_we),
    .host_stat_re(host_stat_re), .host_be(host_be), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .ar_q(ar_q), .regf_idx(regf_idx), .regf_q(regf_q),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data), .cmd_kind(cmd_kind),
    .cur_cmd(cur_cmd), .prm_count(prm_count), .prm_sel(prm_sel), .prm_q(prm_q)
  );

  int n_chk = 0, n_fail = 0;

  // reference model
  logic [7:0] mreg [256];
  logic [7:0] ar_m = '0;
  logic [7:0] mq_d [16];
  logic [1:0] mq_t [16];
  int         mq_n = 0;
  logic       ced_m = 1'b1, err_m = 1'b0;
  logic [7:0] pbuf_m [16];
  int         pcnt_m = 0;
  logic [7:0] cur_m = '0;

  function automatic logic [7:0] st_m();
    return {err_m, 1'b0, ced_m, 3'b000, (mq_n < 16), (mq_n == 0)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_addr(input logic [15:0] v, input logic [1:0] be);
    host_addr_we = 1'b1; host_be = be; host_wdata = v;
    tick();
    host_addr_we = 1'b0; host_be = 2'b00;
    if (be[0]) ar_m = v[7:0];
  endtask

  task automatic m_push(input logic [7:0] d, input logic [1:0] t);
    if (mq_n < 16) begin
      mq_d[mq_n] = d; mq_t[mq_n] = t; mq_n++;
    end else err_m = 1'b1;
  endtask

  task automatic wr_data(input logic [15:0] v, input logic [1:0] be);
    host_data_we = 1'b1; host_be = be; host_wdata = v;
    tick();
    host_data_we = 1'b0; host_be = 2'b00;
    if (be[1]) mreg[ar_m] = v[15:8];
    if (be[0]) mreg[ar_m + 8'd1] = v[7:0];
    if (ar_m == 8'd0) begin
      m_push(v[15:8], ced_m ? 2'b10 : 2'b01);
      m_push(v[7:0], 2'b01);
    end
    if (ar_m == 8'd2 && be[1] && v[15]) begin
      mq_n = 0; ced_m = 1'b1; err_m = 1'b0; pcnt_m = 0;
    end
    if (ar_m[7]) ar_m = ar_m + 8'd2;
  endtask

  task automatic rd_stat(input string req);
    host_stat_re = 1'b1;
    tick();
    host_stat_re = 1'b0;
    check(req, host_rdata, {8'h00, st_m()});
  endtask

  task automatic chk_head(input string req);
    if (mq_n == 0) begin
      check(req, {cmd_valid, cmd_kind}, 3'b000);
    end else begin
      check(req, {cmd_valid, cmd_kind, cmd_data}, {1'b1, mq_t[0], mq_d[0]});
    end
  endtask

  task automatic pop1();
    chk_head("R6 head before pop");
    cmd_ready = 1'b1;
    tick();
    cmd_ready = 1'b0;
    if (mq_n > 0) begin
      if (mq_t[0] == 2'b10) begin
        ced_m = 1'b0; pcnt_m = 0; cur_m = mq_d[0];
      end else if (pcnt_m < 16) begin
        pbuf_m[pcnt_m] = mq_d[0]; pcnt_m++;
      end
      for (int k = 0; k < 15; k++) begin
        mq_d[k] = mq_d[k+1]; mq_t[k] = mq_t[k+1];
      end
      mq_n--;
    end
  endtask

  task automatic chk_prm(input string req);
    check(req, prm_count, pcnt_m);
    check(req, cur_cmd, cur_m);
    for (int k = 0; k < pcnt_m; k++) begin
      prm_sel = 4'(k);
      #1;
      check(req, prm_q, pbuf_m[k]);
    end
  endtask

  task automatic do_abort();
    wr_addr(16'h0002, 2'b01);
    wr_data(16'h8000, 2'b11);
    wr_addr(16'h0000, 2'b01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all) actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state, R11 idle read data
    check("R1 ar", ar_q, 8'h00);
    check("R1 queue", {cmd_valid, cmd_kind}, 3'b000);
    check("R1 prm_count", prm_count, 0);
    check("R11 idle rdata", host_rdata, 16'h0000);
    rd_stat("R1 status 0x23");
    tick();
    check("R11 rdata cleared", host_rdata, 16'h0000);

    // R2 address load sweep
    for (int v = 0; v < 256; v++) begin
      wr_addr({8'(~v), 8'(v)}, 2'b01);
      check("R2 load", ar_q, ar_m);
      wr_addr({8'(v), 8'(~v)}, 2'b10);
      check("R2 high lane ignored", ar_q, ar_m);
    end

    // R3 / R4 register file sweep, full lanes then mixed lanes
    for (int pass = 0; pass < 2; pass++) begin
      for (int a = 4; a < 256; a++) begin
        logic [1:0] be;
        logic [7:0] a8;
        a8 = 8'(a);
        be = (pass == 0) ? 2'b11 : 2'(a % 4);
        wr_addr({8'h00, a8}, 2'b01);
        wr_data({a8 ^ 8'(8'h5A + pass), ~a8 + 8'(pass)}, be);
        check("R4 address step", ar_q, ar_m);
        regf_idx = a8;
        #1;
        check("R3 high lane", regf_q, mreg[a8]);
        regf_idx = a8 + 8'd1;
        #1;
        check("R3 low lane", regf_q, mreg[a8 + 8'd1]);
      end
    end

    // R5 / R10 tagging and command tracking
    wr_addr(16'h0000, 2'b01);
    wr_data(16'hA1B2, 2'b11);
    check("R4 hold at 0", ar_q, 8'h00);
    chk_head("R5 command tag");
    rd_stat("R7 status after push");
    pop1();
    chk_head("R5 parameter tag");
    rd_stat("R10 command end cleared");
    pop1();
    chk_prm("R10 parameter collect");
    wr_data(16'hC3D4, 2'b11);
    chk_head("R5 high byte as parameter");

    // R9 abort ignored without high lane, then taken
    wr_addr(16'h0002, 2'b01);
    wr_data(16'h8000, 2'b01);
    chk_head("R9 no abort on low lane");
    rd_stat("R9 status unchanged");
    wr_data(16'h8000, 2'b11);
    chk_head("R9 abort flush");
    rd_stat("R9 status 0x23");
    chk_prm("R9 parameter count cleared");

    // R8 fill, overflow, one-free-slot case
    wr_addr(16'h0000, 2'b01);
    for (int w = 0; w < 8; w++) wr_data(16'(16'h1000 + w * 16'h0101), 2'b11);
    rd_stat("R7 full status");
    wr_data(16'hEEFF, 2'b11);
    rd_stat("R8 overflow error");
    pop1();
    wr_data(16'h7788, 2'b11);
    rd_stat("R8 single slot");
    for (int k = 0; k < 16; k++) pop1();
    chk_head("R6 drained");
    rd_stat("R7 empty status");
    chk_prm("R10 after drain");

    // soak: mixed writes, pops, stalls, aborts
    do_abort();
    lfsr = 16'hACE1;
    for (int it = 0; it < 600; it++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[7:2] == 6'd0) begin
        do_abort();
      end else begin
        case (lfsr[1:0])
          2'd0, 2'd1: wr_data(lfsr ^ 16'(it), 2'b11);
          2'd2: pop1();
          default: begin
            tick();
            chk_head("R6 stall hold");
          end
        endcase
      end
      chk_head("R6 soak head");
      if (it % 16 == 0) rd_stat("R7 soak status");
      if (it % 64 == 0) chk_prm("R10 soak parameters");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule